// File: doc/BRIEF.md
# Stereo Serial Output Port

This block sends one left and one right 16-bit sample per frame on a single serial data line. A frame has 64 bit slots, 32 per channel half. Each word goes out most significant bit first, and the left half always comes before the right half. Four static configuration inputs select the format: where the frame sync edge falls relative to the first data bit, whether the block drives the bit clock and sync or receives them, which 16 slots of a half carry data, and whether idle slots release the line or hold it low.

In master mode, level bit-clock and sync signals from the chip's timing block step the port, and registered copies of them leave on the clock outputs. In slave mode, the external bit clock and sync pass through a two-flop synchroniser clocked by the internal sample clock before their edges are detected. The data line has a separate drive enable for the pad buffer outside the block. Two ports can therefore share one wire when both run as slaves, both release idle slots, and each uses the opposite justification.

Top module: `stereo_ser_port`

## Requirements
- R1: A frame is 64 slots, numbered from 0 at frame start. Slots 0 to 31 form the left half and slots 32 to 63 the right half. Each half sends its 16-bit word most significant bit first. The data output and its enable change only in the clock cycle that acts on a detected bit-clock rising edge.
- R2: With `cfg_right_just` low, data occupies slots 0 to 15 of each half (bit 15 in slot 0). With it high, data occupies slots 16 to 31 of each half (bit 15 in slot 16).
- R3: In a slot without data, `sdo` is 0. `sdo_oe` equals `cfg_idle_low`: 0 releases the line and 1 drives it low.
- R4: Sync is sampled at each bit-clock rise. With `cfg_sync_coin` low, slot 0 starts at the bit-clock rise after the one at which sync is first seen high. With it high, slot 0 starts at that same rise.
- R5: In master mode (`cfg_slave` low), `bclk_out` and `sync_out` copy `tm_bclk` and `tm_sync` one clock later and `clk_oe` is 1. A bit-clock rise presented on `tm_bclk` updates the data output at the next clock edge. In slave mode, `clk_oe`, `bclk_out` and `sync_out` are 0.
- R6: In slave mode, `ext_bclk` and `ext_sync` pass through two synchroniser flops, so the data output responds two clock edges later than it would to the same pattern in master mode.
- R7: Both words are captured together when slot 0 begins. Changes to `word_left` or `word_right` in any other slot do not affect the frame being sent.
- R8: Every sync rising edge realigns the slot count, including one that arrives in the middle of a frame.
- R9: After reset, `sdo_oe` and `sdo` stay 0 until the first slot 0 that follows a detected sync rising edge.
- R10: While reset is asserted, every output is 0.
- R11: Two slave ports that share bit clock and sync, both with `cfg_idle_low` low and with opposite justification, never assert `sdo_oe` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal sample clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_sync_coin | input | 1 | 0: sync one bit early, 1: sync coincident with first bit |
| cfg_slave | input | 1 | 1: bit clock and sync come from outside |
| cfg_right_just | input | 1 | 1: data in the last 16 slots of each half |
| cfg_idle_low | input | 1 | 1: drive low in idle slots, 0: release |
| tm_bclk | input | 1 | bit clock level from the timing block (master) |
| tm_sync | input | 1 | sync level from the timing block (master) |
| ext_bclk | input | 1 | external bit clock (slave, asynchronous) |
| ext_sync | input | 1 | external sync (slave, asynchronous) |
| word_left | input | 16 | left channel sample |
| word_right | input | 16 | right channel sample |
| bclk_out | output | 1 | bit clock for the pad in master mode |
| sync_out | output | 1 | sync for the pad in master mode |
| clk_oe | output | 1 | pad enable for bit clock and sync |
| sdo | output | 1 | serial data |
| sdo_oe | output | 1 | pad enable for serial data |

## Verification
A bit-clock rise presented on the master inputs is due on `sdo` and `sdo_oe` one clock edge later. On the slave inputs it is due three edges later, and the copied clocks on `bclk_out` and `sync_out` are due one edge after the timing inputs. The bench's behavioural frame model runs on the stimulus as it is applied and pushes each expected value into a history queue. Every clock, at the falling edge, the bench compares the outputs with the entry that is as old as the mode's latency. A second slave port with opposite justification shares the external clocks, and the bench checks it against its own model and for overlapping enables.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int SOP_WORD_W_DEF    = 16;
    localparam int SOP_SYNC_STAGES   = 2;

    // drive state of the serial data pin for one slot
    typedef struct packed {
        logic data;
        logic drive;
    } sop_pin_t;

    // pin value for a slot, given whether it carries data and its bit value
    function automatic sop_pin_t sop_slot_pin(input logic running,
                                              input logic in_data,
                                              input logic bit_val,
                                              input logic idle_low);
        sop_pin_t p;
        if (!running) begin
            p.data  = 1'b0;
            p.drive = 1'b0;
        end else if (in_data) begin
            p.data  = bit_val;
            p.drive = 1'b1;
        end else begin
            p.data  = 1'b0;
            p.drive = idle_low;
        end
        return p;
    endfunction

endpackage

// File: rtl/sop_edge_front.sv
module sop_edge_front #(
    parameter int SYNC_STAGES = sop_pkg::SOP_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic tm_bclk,
    input  logic tm_sync,
    input  logic ext_bclk,
    input  logic ext_sync,
    output logic bclk_rise,
    output logic sync_level,
    output logic bclk_pad,
    output logic sync_pad,
    output logic clk_drive
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] bck_sh;
        logic [SYNC_STAGES-1:0] syn_sh;
        logic                   bck_prev;
        logic                   bclk_pad;
        logic                   sync_pad;
        logic                   clk_drive;
    } front_t;

    front_t st_d, st_q;
    logic   cur_bclk, cur_sync;

    always_comb begin
        st_d        = st_q;
        st_d.bck_sh = {st_q.bck_sh[TOP-1:0], ext_bclk};
        st_d.syn_sh = {st_q.syn_sh[TOP-1:0], ext_sync};

        cur_bclk = slave_mode ? st_q.bck_sh[TOP] : tm_bclk;
        cur_sync = slave_mode ? st_q.syn_sh[TOP] : tm_sync;

        st_d.bck_prev  = cur_bclk;
        st_d.bclk_pad  = ~slave_mode & tm_bclk;
        st_d.sync_pad  = ~slave_mode & tm_sync;
        st_d.clk_drive = ~slave_mode;

        bclk_rise  = cur_bclk & ~st_q.bck_prev;
        sync_level = cur_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_pad  = st_q.bclk_pad;
    assign sync_pad  = st_q.sync_pad;
    assign clk_drive = st_q.clk_drive;

    AST_SLAVE_NO_CLK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slave_mode) |-> !clk_drive && !bclk_pad && !sync_pad); // R5

    AST_SLAVE_RISE_RESAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode && $past(slave_mode) && $past(slave_mode, 2) && bclk_rise
        |-> $past(ext_bclk, 2)); // R6

endmodule

// File: rtl/sop_slot_ctr.sv
module sop_slot_ctr #(
    parameter  int FRAME_SLOTS = 64,
    localparam int SLOT_W      = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              sync_level,
    input  logic              sync_coin,
    output logic [SLOT_W-1:0] slot_nx,
    output logic              run_nx,
    output logic              run_cur,
    output logic              frame_load
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              sprev;
        logic              armed;
        logic              run;
    } ctr_t;

    ctr_t st_d, st_q;
    logic sync_rise;

    always_comb begin
        st_d      = st_q;
        sync_rise = adv & sync_level & ~st_q.sprev;
        if (adv) begin
            st_d.sprev = sync_level;
            if (sync_rise) begin
                st_d.slot  = sync_coin ? '0 : LAST;
                st_d.armed = 1'b1;
            end else if (st_q.slot == LAST) begin
                st_d.slot = '0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
            if (st_d.armed && st_d.slot == '0) st_d.run = 1'b1;
        end
        frame_load = adv & st_d.run & (st_d.slot == '0);
        slot_nx    = st_d.slot;
        run_nx     = st_d.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_cur = st_q.run;

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.slot)); // R1

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !(sync_level && !st_q.sprev) && st_q.slot != LAST
        |=> st_q.slot == $past(st_q.slot) + 1'b1); // R1

    AST_RESYNC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        adv && sync_level && !st_q.sprev
        |=> st_q.slot == ($past(sync_coin) ? '0 : LAST)); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        run_cur |=> run_cur); // R9

endmodule

// File: rtl/sop_serialiser.sv
module sop_serialiser #(
    parameter  int WORD_W     = sop_pkg::SOP_WORD_W_DEF,
    parameter  int HALF_SLOTS = 2 * WORD_W,
    localparam int SLOT_W     = $clog2(2 * HALF_SLOTS),
    localparam int POS_W      = SLOT_W - 1,
    localparam int IDX_W      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [SLOT_W-1:0] slot_nx,
    input  logic              run_nx,
    input  logic              run_cur,
    input  logic              frame_load,
    input  logic              right_just,
    input  logic              idle_low,
    input  logic [WORD_W-1:0] word_l,
    input  logic [WORD_W-1:0] word_r,
    output logic              sdo,
    output logic              sdo_oe
);

    import sop_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] shl;
        logic [WORD_W-1:0] shr;
        logic              sdo;
        logic              oe;
    } ser_t;

    ser_t              st_d, st_q;
    logic              in_right;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  idx_full;
    logic [IDX_W-1:0]  idx;
    logic              in_data;
    logic              bit_val;
    logic [WORD_W-1:0] src_l, src_r;
    sop_pin_t          pin;

    always_comb begin
        st_d = st_q;
        if (frame_load) begin
            st_d.shl = word_l;
            st_d.shr = word_r;
        end
        src_l = st_d.shl;
        src_r = st_d.shr;

        in_right = slot_nx[SLOT_W-1];
        pos      = slot_nx[POS_W-1:0];
        if (right_just) begin
            in_data  = pos >= POS_W'(HALF_SLOTS - WORD_W);
            idx_full = POS_W'(HALF_SLOTS - 1) - pos;
        end else begin
            in_data  = pos < POS_W'(WORD_W);
            idx_full = POS_W'(WORD_W - 1) - pos;
        end
        idx     = idx_full[IDX_W-1:0];
        bit_val = in_right ? src_r[idx] : src_l[idx];
        pin     = sop_slot_pin(run_nx, in_data, bit_val, idle_low);

        if (adv) begin
            st_d.sdo = pin.data;
            st_d.oe  = pin.drive;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.sdo;
    assign sdo_oe = st_q.oe;

    AST_OUT_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.sdo) && $stable(st_q.oe)); // R1

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(st_q.shl) && $stable(st_q.shr)); // R7

    AST_QUIET_UNTIL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_cur |-> !st_q.oe && !st_q.sdo); // R9

    AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe && !st_q.sdo && $past(adv) && $past(!idle_low) |-> $past(in_data)); // R3

endmodule

// File: rtl/stereo_ser_port.sv
module stereo_ser_port #(
    parameter  int WORD_W      = sop_pkg::SOP_WORD_W_DEF,
    parameter  int SYNC_STAGES = sop_pkg::SOP_SYNC_STAGES,
    localparam int HALF_SLOTS  = 2 * WORD_W,
    localparam int FRAME_SLOTS = 2 * HALF_SLOTS,
    localparam int SLOT_W      = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sync_coin,
    input  logic              cfg_slave,
    input  logic              cfg_right_just,
    input  logic              cfg_idle_low,
    input  logic              tm_bclk,
    input  logic              tm_sync,
    input  logic              ext_bclk,
    input  logic              ext_sync,
    input  logic [WORD_W-1:0] word_left,
    input  logic [WORD_W-1:0] word_right,
    output logic              bclk_out,
    output logic              sync_out,
    output logic              clk_oe,
    output logic              sdo,
    output logic              sdo_oe
);

    logic              bclk_rise;
    logic              sync_level;
    logic [SLOT_W-1:0] slot_nx;
    logic              run_nx;
    logic              run_cur;
    logic              frame_load;

    sop_edge_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (cfg_slave),
        .tm_bclk    (tm_bclk),
        .tm_sync    (tm_sync),
        .ext_bclk   (ext_bclk),
        .ext_sync   (ext_sync),
        .bclk_rise  (bclk_rise),
        .sync_level (sync_level),
        .bclk_pad   (bclk_out),
        .sync_pad   (sync_out),
        .clk_drive  (clk_oe)
    );

    sop_slot_ctr #(
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (bclk_rise),
        .sync_level (sync_level),
        .sync_coin  (cfg_sync_coin),
        .slot_nx    (slot_nx),
        .run_nx     (run_nx),
        .run_cur    (run_cur),
        .frame_load (frame_load)
    );

    sop_serialiser #(
        .WORD_W     (WORD_W),
        .HALF_SLOTS (HALF_SLOTS)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (bclk_rise),
        .slot_nx    (slot_nx),
        .run_nx     (run_nx),
        .run_cur    (run_cur),
        .frame_load (frame_load),
        .right_just (cfg_right_just),
        .idle_low   (cfg_idle_low),
        .word_l     (word_left),
        .word_r     (word_right),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

endmodule

// File: tb/stereo_ser_port_tb_top.sv
module stereo_ser_port_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_coin = 1'b0, cfg_slave = 1'b0, cfg_right = 1'b0, cfg_idle = 1'b0;
    logic tm_bclk = 1'b0, tm_sync = 1'b0, ext_bclk = 1'b0, ext_sync = 1'b0;
    logic [15:0] wl = 16'hA5C3, wr = 16'h3C5A;
    logic bclk_out, sync_out, clk_oe, sdo, sdo_oe;
    logic b_bclk_out, b_sync_out, b_clk_oe, b_sdo, b_sdo_oe;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    bit share_chk = 0;

    always #10 clk = ~clk;

    stereo_ser_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sync_coin(cfg_coin), .cfg_slave(cfg_slave),
        .cfg_right_just(cfg_right), .cfg_idle_low(cfg_idle),
        .tm_bclk(tm_bclk), .tm_sync(tm_sync), .ext_bclk(ext_bclk), .ext_sync(ext_sync),
        .word_left(wl), .word_right(wr),
        .bclk_out(bclk_out), .sync_out(sync_out), .clk_oe(clk_oe), .sdo(sdo), .sdo_oe(sdo_oe));

    // partner port for the shared-line case: slave, right justified, idle released
    stereo_ser_port dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_sync_coin(cfg_coin), .cfg_slave(1'b1),
        .cfg_right_just(1'b1), .cfg_idle_low(1'b0),
        .tm_bclk(1'b0), .tm_sync(1'b0), .ext_bclk(ext_bclk), .ext_sync(ext_sync),
        .word_left(wr), .word_right(wl),
        .bclk_out(b_bclk_out), .sync_out(b_sync_out), .clk_oe(b_clk_oe), .sdo(b_sdo), .sdo_oe(b_sdo_oe));

    // behavioural frame model, index 0 = dut_i, 1 = dut_b
    int          m_slot [2];
    bit          m_sprev[2], m_armed[2], m_run[2], m_sdo[2], m_oe[2], m_data[2];
    logic [15:0] m_shl[2], m_shr[2];

    bit    qa_sdo[$], qa_oe[$], qa_bo[$], qa_so[$], qa_coe[$];
    string qa_tag[$];
    bit    qb_sdo[$], qb_oe[$];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_slot[c] = 0; m_sprev[c] = 0; m_armed[c] = 0; m_run[c] = 0;
            m_sdo[c] = 0; m_oe[c] = 0; m_data[c] = 0; m_shl[c] = 0; m_shr[c] = 0;
        end
    endtask

    task automatic model_step(input int c, input bit syn, input bit coin, input bit right,
                              input bit idle, input logic [15:0] lw, input logic [15:0] rw);
        int pos, bi;
        bit sr;
        sr = syn && !m_sprev[c];
        m_sprev[c] = syn;
        if (sr) begin
            m_slot[c] = coin ? 0 : 63;
            m_armed[c] = 1;
        end else begin
            m_slot[c] = (m_slot[c] + 1) % 64;
        end
        if (m_armed[c] && m_slot[c] == 0) m_run[c] = 1;
        if (m_run[c] && m_slot[c] == 0) begin
            m_shl[c] = lw;
            m_shr[c] = rw;
        end
        pos = m_slot[c] % 32;
        m_data[c] = right ? (pos >= 16) : (pos < 16);
        bi = right ? 31 - pos : 15 - pos;
        if (!m_run[c]) begin
            m_sdo[c] = 0; m_oe[c] = 0;
        end else if (m_data[c]) begin
            m_sdo[c] = (m_slot[c] >= 32) ? m_shr[c][bi] : m_shl[c][bi];
            m_oe[c] = 1;
        end else begin
            m_sdo[c] = 0; m_oe[c] = idle;
        end
    endtask

    task automatic run_phase(input bit slave, input bit coin, input bit right, input bit idle,
                             input int resync_at, input string tag);
        int ph, gp, cnt, lat;
        bit syn, rise, bck;
        string t;
        rst_n = 0;
        cfg_slave = slave; cfg_coin = coin; cfg_right = right; cfg_idle = idle;
        tm_bclk = 0; tm_sync = 0; ext_bclk = 0; ext_sync = 0;
        repeat (3) @(negedge clk);
        // R10: all outputs low while reset is held
        chk({bclk_out, sync_out, clk_oe, sdo, sdo_oe} == 5'b0, "R10", "reset outputs",
            {bclk_out, sync_out, clk_oe, sdo, sdo_oe}, 0);
        model_reset();
        qa_sdo.delete(); qa_oe.delete(); qa_bo.delete(); qa_so.delete(); qa_coe.delete(); qa_tag.delete();
        qb_sdo.delete(); qb_oe.delete();
        for (int i = 0; i < 2; i++) begin
            qa_sdo.push_back(0); qa_oe.push_back(0); qa_bo.push_back(0); qa_so.push_back(0);
            qa_coe.push_back(0); qa_tag.push_back("R10"); qb_sdo.push_back(0); qb_oe.push_back(0);
        end
        rst_n = 1;
        lat = slave ? 2 : 0;
        ph = 3; gp = 0; cnt = 0; syn = 0;
        while (cnt < 20 + 3 * 64) begin
            ph = (ph + 1) % 4;
            rise = (ph == 0);
            bck = (ph < 2);
            if (rise) begin
                cnt++;
                gp = (gp + 1) % 64;
                if (resync_at > 0 && cnt == resync_at) gp = (gp + 20) % 64;
                syn = (cnt >= 20) && (((gp - (coin ? 0 : 63) + 64) % 64) < 32);
                if (gp == 5 || gp == 40) begin
                    wl = wl * 16'd25173 + 16'd13849;
                    wr = wr * 16'd20077 + 16'd12345;
                end
            end
            if (slave) begin
                ext_bclk = bck; ext_sync = syn;
            end else begin
                tm_bclk = bck; tm_sync = syn;
            end
            if (rise) begin
                model_step(0, syn, coin, right, idle, wl, wr);
                if (slave) model_step(1, syn, coin, 1'b1, 1'b0, wr, wl);
            end
            if (!m_run[0])           t = "R9";
            else if (!m_data[0])     t = "R3";
            else if (slave)          t = "R6";
            else                     t = tag;
            qa_sdo.push_back(m_sdo[0]); qa_oe.push_back(m_oe[0]); qa_tag.push_back(t);
            qa_bo.push_back(!slave && bck); qa_so.push_back(!slave && syn); qa_coe.push_back(!slave);
            qb_sdo.push_back(m_sdo[1]); qb_oe.push_back(m_oe[1]);
            @(negedge clk);
            chk(sdo == qa_sdo[qa_sdo.size()-1-lat], qa_tag[qa_tag.size()-1-lat], "sdo",
                sdo, qa_sdo[qa_sdo.size()-1-lat]);
            chk(sdo_oe == qa_oe[qa_oe.size()-1-lat], qa_tag[qa_tag.size()-1-lat], "sdo_oe",
                sdo_oe, qa_oe[qa_oe.size()-1-lat]);
            // R5: copied clocks and their enable
            chk(bclk_out == qa_bo[qa_bo.size()-1], "R5", "bclk_out", bclk_out, qa_bo[qa_bo.size()-1]);
            chk(sync_out == qa_so[qa_so.size()-1], "R5", "sync_out", sync_out, qa_so[qa_so.size()-1]);
            chk(clk_oe == qa_coe[qa_coe.size()-1], "R5", "clk_oe", clk_oe, qa_coe[qa_coe.size()-1]);
            // R11: partner port follows its own model; no overlapping enables on a shared line
            chk(b_sdo == qb_sdo[qb_sdo.size()-3] && b_sdo_oe == qb_oe[qb_oe.size()-3], "R11",
                "partner pin", {b_sdo_oe, b_sdo}, {qb_oe[qb_oe.size()-3], qb_sdo[qb_sdo.size()-3]});
            if (share_chk)
                chk(!(sdo_oe && b_sdo_oe), "R11", "enable overlap", {sdo_oe, b_sdo_oe}, 0);
            if (qa_sdo.size() > 8) begin
                void'(qa_sdo.pop_front()); void'(qa_oe.pop_front()); void'(qa_bo.pop_front());
                void'(qa_so.pop_front()); void'(qa_coe.pop_front()); void'(qa_tag.pop_front());
                void'(qb_sdo.pop_front()); void'(qb_oe.pop_front());
            end
        end
    endtask

    initial begin
        run_phase(0, 0, 0, 0, 0,   "R1");  // master, early sync, left, released idle
        run_phase(0, 1, 1, 1, 0,   "R2");  // master, coincident sync, right, idle low
        run_phase(0, 1, 0, 1, 0,   "R4");  // master, coincident sync, left, idle low
        run_phase(0, 0, 1, 0, 0,   "R7");  // master, early sync, right: words change mid frame
        run_phase(0, 0, 0, 1, 130, "R8");  // master with a sync jump in mid frame
        share_chk = 1;
        run_phase(1, 0, 0, 0, 0,   "R6");  // slave, shared line with partner
        share_chk = 0;
        run_phase(1, 1, 1, 1, 0,   "R6");  // slave, coincident, right, idle low
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog act=%0d exp<%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule